// File: doc/BRIEF.md
# Interrupt request routing crossbar

This block sits between a wide field of peripheral interrupt request lines and the much narrower input set of an interrupt controller. Each controller input line owns one select register that names the peripheral source driven onto it. Software programs these registers over a small register bus. The routing itself is combinational, so a level-sensitive, active-high request reaches the controller with no added latency and no change in polarity.

Some controller inputs are not routable. Reserved lines have no usable register: writes to them are dropped, and reads return the safe-map index. Skipped lines have a normal read/write register, but the output is tied to a dedicated fixed input, so the programmed value has no effect. Every other line starts from reset selecting the safe-map source. A programmed index that names no existing source drives the line low.

Top module: `irq_route_xbar`

## Requirements
- R1: Reset (synchronous, active high) loads every select register with SAFE_SRC (default 0). After reset every routed output follows `src_irq_i[SAFE_SRC]`.
- R2: The register of line n sits at byte offset n*REG_BYTES. A write (`reg_wr_en` high at a clock edge) to an aligned in-range address of a non-reserved line stores the full REG_BYTES*8-bit `reg_wdata`. `reg_rdata` returns the stored value combinationally from `reg_addr`. A write to a misaligned address, or to an address at or above NUM_OUT*REG_BYTES, changes nothing, and a read there returns 0.
- R3: A routed line n drives `ctl_irq_o[n] = src_irq_i[sel]` combinationally, with the same polarity, where sel is its register value.
- R4: A routed line whose register holds a value at or above NUM_SRC drives 0.
- R5: Reserved lines (default 0, 1, 2, 3, 5, 6, 131, 132) drive `fixed_irq_i[n]`. Writes to them are ignored, and reads of them return SAFE_SRC.
- R6: Skipped lines (default 10, 133, 139, 140) drive `fixed_irq_i[n]` whatever their register holds. Their register is still written and read back normally.
- R7: Several routed lines may select the same source, and each of them then carries that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (9) | Byte address for write and read |
| reg_wdata | input | REG_BYTES*8 (16) | Write data |
| reg_rdata | output | REG_BYTES*8 (16) | Combinational read data for reg_addr |
| src_irq_i | input | NUM_SRC (400) | Peripheral interrupt requests |
| fixed_irq_i | input | NUM_OUT (160) | Hard-wired requests for reserved and skipped lines |
| ctl_irq_o | output | NUM_OUT (160) | Requests to the controller inputs |

## Verification
The bench probes the edges of the index range. It uses source 399 and the out-of-range values 400 and 0xFFFF; a design that checked the range wrongly would either drop the top source or leak an undefined bit. It writes to reserved and skipped lines and then reads them back and watches their outputs, which exposes a design that lets a reserved register change or lets a skipped register take over routing. It also issues misaligned and beyond-range writes, followed by a full register sweep, and asserts reset in the middle of the run. These catch aliasing in the address decode and registers that do not return to the safe index.

// File: rtl/irq_xbar_pkg.sv
package irq_xbar_pkg;

    localparam int unsigned LIST_W = 256;

    localparam logic [LIST_W-1:0] DFLT_RSVD =
        (LIST_W'(1) << 0)   | (LIST_W'(1) << 1)   | (LIST_W'(1) << 2)   |
        (LIST_W'(1) << 3)   | (LIST_W'(1) << 5)   | (LIST_W'(1) << 6)   |
        (LIST_W'(1) << 131) | (LIST_W'(1) << 132);

    localparam logic [LIST_W-1:0] DFLT_SKIP =
        (LIST_W'(1) << 10)  | (LIST_W'(1) << 133) |
        (LIST_W'(1) << 139) | (LIST_W'(1) << 140);

    typedef enum logic [1:0] {
        KIND_ROUTED   = 2'd0,
        KIND_RESERVED = 2'd1,
        KIND_SKIPPED  = 2'd2
    } line_kind_e;

    typedef struct packed {
        logic        hit;      // aligned and inside the register window
        logic        aligned;
        logic [15:0] line;
    } reg_dec_t;

    function automatic int unsigned width_of(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic line_kind_e kind_of(input logic rsvd, input logic skip);
        if (rsvd)      return KIND_RESERVED;
        else if (skip) return KIND_SKIPPED;
        return KIND_ROUTED;
    endfunction

    // Register stride is 1, 2 or 4 bytes, so the divide is a shift.
    function automatic reg_dec_t decode_addr(input logic [31:0] a,
                                             input int unsigned reg_bytes,
                                             input int unsigned n_out);
        reg_dec_t    d;
        int unsigned sh;
        logic [31:0] ln;
        sh = (reg_bytes == 4) ? 2 : ((reg_bytes == 2) ? 1 : 0);
        ln = a >> sh;
        d.aligned = ((a & ((32'd1 << sh) - 32'd1)) == 32'd0);
        d.hit     = d.aligned && (ln < n_out);
        d.line    = ln[15:0];
        return d;
    endfunction

endpackage

// File: rtl/irq_xbar_regs.sv
module irq_xbar_regs
    import irq_xbar_pkg::*;
#(
    parameter int unsigned NUM_OUT   = 160,
    parameter int unsigned REG_BYTES = 2,
    parameter int unsigned SAFE_SRC  = 0,
    parameter int unsigned ADDR_W    = 9,
    parameter logic [NUM_OUT-1:0] RSVD_MASK = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [REG_BYTES*8-1:0]        wdata,
    output logic [REG_BYTES*8-1:0]        rdata,
    output logic [NUM_OUT*REG_BYTES*8-1:0] sel_flat_o
);
    localparam int unsigned REG_W  = REG_BYTES * 8;
    localparam int unsigned LINE_W = width_of(NUM_OUT);
    localparam logic [REG_W-1:0] SAFE_VAL = REG_W'(SAFE_SRC);

    reg_dec_t           dec;
    logic [LINE_W-1:0]  line_idx;
    logic [REG_W-1:0]   sel_q [NUM_OUT];

    always_comb begin
        dec      = decode_addr(32'(addr), REG_BYTES, NUM_OUT);
        line_idx = LINE_W'(dec.line);
    end

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_line
        if (RSVD_MASK[n]) begin : g_rsvd
            // No storage: the line reads back as the safe index.
            assign sel_q[n] = SAFE_VAL;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    sel_q[n] <= SAFE_VAL;
                else if (wr_en && dec.hit && (line_idx == LINE_W'(n)))
                    sel_q[n] <= wdata;
            end
        end
        assign sel_flat_o[n*REG_W +: REG_W] = sel_q[n];
    end

    always_comb begin
        rdata = '0;
        if (dec.hit)
            rdata = sel_q[line_idx];
    end

endmodule

// File: rtl/irq_xbar_lane.sv
module irq_xbar_lane
    import irq_xbar_pkg::*;
#(
    parameter int unsigned NUM_SRC = 400,
    parameter int unsigned REG_W   = 16,
    parameter line_kind_e  KIND    = KIND_ROUTED
) (
    input  logic [NUM_SRC-1:0] src_irq_i,
    input  logic               fixed_irq_i,
    input  logic [REG_W-1:0]   sel_i,
    output logic               irq_o
);
    localparam int unsigned SRC_IW = width_of(NUM_SRC);
    localparam int unsigned CMP_W  = max_of(REG_W, SRC_IW + 1);

    if (KIND == KIND_ROUTED) begin : g_route
        logic [SRC_IW-1:0] idx;
        logic [CMP_W-1:0]  sel_ext;
        logic              in_range;
        logic              fixed_unused;

        assign fixed_unused = fixed_irq_i;
        assign idx          = SRC_IW'(sel_i);
        assign sel_ext      = CMP_W'(sel_i);
        assign in_range     = sel_ext < CMP_W'(NUM_SRC);
        assign irq_o        = in_range ? src_irq_i[idx] : 1'b0;
    end else begin : g_fixed
        logic [NUM_SRC-1:0] src_unused;
        logic [REG_W-1:0]   sel_unused;

        assign src_unused = src_irq_i;
        assign sel_unused = sel_i;
        assign irq_o      = fixed_irq_i;
    end

endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
    import irq_xbar_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 400,
    parameter int unsigned NUM_OUT   = 160,
    parameter int unsigned REG_BYTES = 2,
    parameter int unsigned SAFE_SRC  = 0,
    parameter logic [NUM_OUT-1:0] RSVD_MASK = DFLT_RSVD[NUM_OUT-1:0],
    parameter logic [NUM_OUT-1:0] SKIP_MASK = DFLT_SKIP[NUM_OUT-1:0],
    parameter int unsigned ADDR_W    = width_of(NUM_OUT * REG_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr_en,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [REG_BYTES*8-1:0] reg_wdata,
    output logic [REG_BYTES*8-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0]     src_irq_i,
    input  logic [NUM_OUT-1:0]     fixed_irq_i,
    output logic [NUM_OUT-1:0]     ctl_irq_o
);
    localparam int unsigned REG_W = REG_BYTES * 8;

    if (!(REG_BYTES == 1 || REG_BYTES == 2 || REG_BYTES == 4)) begin : g_bad_stride
        $error("REG_BYTES must be 1, 2 or 4");
    end

    logic [NUM_OUT*REG_W-1:0] sel_flat;

    irq_xbar_regs #(
        .NUM_OUT   (NUM_OUT),
        .REG_BYTES (REG_BYTES),
        .SAFE_SRC  (SAFE_SRC),
        .ADDR_W    (ADDR_W),
        .RSVD_MASK (RSVD_MASK)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .sel_flat_o (sel_flat)
    );

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_lane
        localparam line_kind_e KIND = kind_of(RSVD_MASK[n], SKIP_MASK[n]);
        irq_xbar_lane #(
            .NUM_SRC (NUM_SRC),
            .REG_W   (REG_W),
            .KIND    (KIND)
        ) u_lane (
            .src_irq_i   (src_irq_i),
            .fixed_irq_i (fixed_irq_i[n]),
            .sel_i       (sel_flat[n*REG_W +: REG_W]),
            .irq_o       (ctl_irq_o[n])
        );
    end

endmodule

// File: rtl/irq_xbar_chk.sv
module irq_xbar_chk
    import irq_xbar_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 400,
    parameter int unsigned NUM_OUT   = 160,
    parameter int unsigned REG_BYTES = 2,
    parameter int unsigned SAFE_SRC  = 0,
    parameter logic [NUM_OUT-1:0] RSVD_MASK = '0,
    parameter logic [NUM_OUT-1:0] SKIP_MASK = '0,
    parameter int unsigned ADDR_W    = 9
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           reg_wr_en,
    input logic [ADDR_W-1:0]              reg_addr,
    input logic [REG_BYTES*8-1:0]         reg_wdata,
    input logic [REG_BYTES*8-1:0]         reg_rdata,
    input logic [NUM_SRC-1:0]             src_irq_i,
    input logic [NUM_OUT-1:0]             fixed_irq_i,
    input logic [NUM_OUT-1:0]             ctl_irq_o,
    input logic [NUM_OUT*REG_BYTES*8-1:0] sel_flat
);
    localparam int unsigned REG_W  = REG_BYTES * 8;
    localparam int unsigned SRC_IW = width_of(NUM_SRC);
    localparam int unsigned CMP_W  = max_of(REG_W, SRC_IW + 1);
    localparam int unsigned LINE_W = width_of(NUM_OUT);

    reg_dec_t          cdec;
    logic [LINE_W-1:0] cline;
    assign cdec  = decode_addr(32'(reg_addr), REG_BYTES, NUM_OUT);
    assign cline = LINE_W'(cdec.line);

    // R2: addresses outside the register window read as zero
    assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !cdec.hit |-> (reg_rdata == '0));

    // R5: a reserved line always reads back the safe index
    assert_rsvd_reads_safe_R5: assert property (@(posedge clk) disable iff (rst)
        (cdec.hit && RSVD_MASK[cline]) |-> (reg_rdata == REG_W'(SAFE_SRC)));

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_chk
        logic [REG_W-1:0]  csel;
        logic [SRC_IW-1:0] cidx;
        logic [CMP_W-1:0]  cext;
        assign csel = sel_flat[n*REG_W +: REG_W];
        assign cidx = SRC_IW'(csel);
        assign cext = CMP_W'(csel);

        if (RSVD_MASK[n] || SKIP_MASK[n]) begin : g_hw
            // R5 / R6: hard-wired lines ignore the routing registers
            assert_hw_line_fixed_R6: assert property (@(posedge clk) disable iff (rst)
                ctl_irq_o[n] == fixed_irq_i[n]);
        end else begin : g_rt
            assert_route_follows_R3: assert property (@(posedge clk) disable iff (rst)
                (cext < CMP_W'(NUM_SRC)) |-> (ctl_irq_o[n] == src_irq_i[cidx]));
            assert_bad_index_low_R4: assert property (@(posedge clk) disable iff (rst)
                (cext >= CMP_W'(NUM_SRC)) |-> !ctl_irq_o[n]);
        end

        if (!RSVD_MASK[n]) begin : g_st
            assert_reset_safe_R1: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (csel == REG_W'(SAFE_SRC)));
            assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
                (reg_wr_en && cdec.hit && (cline == LINE_W'(n))) |=> (csel == $past(reg_wdata)));
        end
    end

endmodule

bind irq_route_xbar irq_xbar_chk #(
    .NUM_SRC   (NUM_SRC),
    .NUM_OUT   (NUM_OUT),
    .REG_BYTES (REG_BYTES),
    .SAFE_SRC  (SAFE_SRC),
    .RSVD_MASK (RSVD_MASK),
    .SKIP_MASK (SKIP_MASK),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .src_irq_i   (src_irq_i),
    .fixed_irq_i (fixed_irq_i),
    .ctl_irq_o   (ctl_irq_o),
    .sel_flat    (sel_flat)
);

// File: tb/irq_route_xbar_tb.sv
`timescale 1ns/1ps
module irq_route_xbar_tb;
    localparam int NSRC = 400;
    localparam int NOUT = 160;
    localparam int RB   = 2;
    localparam int NVEC = 11;
    // {line, select value}
    localparam int VEC [NVEC][2] = '{
        '{7, 5}, '{8, 399}, '{9, 400}, '{159, 123}, '{20, 5}, '{10, 77},
        '{0, 33}, '{131, 200}, '{140, 88}, '{4, 65535}, '{21, 399}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr_en = 1'b0;
    logic [8:0]       reg_addr = '0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic [NSRC-1:0]  src = '0;
    logic [NOUT-1:0]  fix = '0;
    logic [NOUT-1:0]  ctl;

    int checks = 0;
    int fails  = 0;
    int mdl [NOUT];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_route_xbar u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_irq_i(src),
        .fixed_irq_i(fix), .ctl_irq_o(ctl)
    );

    function automatic bit is_rsvd(int n);
        return n inside {0, 1, 2, 3, 5, 6, 131, 132};
    endfunction
    function automatic bit is_skip(int n);
        return n inside {10, 133, 139, 140};
    endfunction
    function automatic bit exp_bit(int n);
        if (is_rsvd(n) || is_skip(n)) return fix[n];
        if (mdl[n] < NSRC) return src[mdl[n]];
        return 1'b0;
    endfunction

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 9'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr_en = 1'b0;
        if ((a % RB) == 0 && (a / RB) < NOUT && !is_rsvd(a / RB))
            mdl[a / RB] = d & 16'hFFFF;
    endtask

    task automatic chk_rd(int a, int exp, string tag);
        @(negedge clk);
        reg_addr = 9'(a);
        #1;
        checks++;
        if (reg_rdata !== 16'(exp)) begin
            fails++;
            $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, reg_rdata, 16'(exp));
        end
    endtask

    task automatic chk_out(string tag);
        int bad;
        bad = -1;
        #1;
        checks++;
        for (int n = NOUT - 1; n >= 0; n--)
            if (ctl[n] !== exp_bit(n)) bad = n;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s line %0d: actual %b expected %b", tag, bad, ctl[bad], exp_bit(bad));
        end
    endtask

    task automatic chk_all_regs(string tag);
        int bad;
        bad = -1;
        for (int n = 0; n < NOUT; n++) begin
            @(negedge clk);
            reg_addr = 9'(n * RB);
            #1;
            if (bad < 0 && reg_rdata !== 16'(is_rsvd(n) ? 0 : mdl[n])) bad = n;
        end
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s register %0d: actual %h expected %h", tag, bad, reg_rdata,
                     16'(is_rsvd(bad) ? 0 : mdl[bad]));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < NOUT; n++) mdl[n] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        string tag;
        int ln, sv;
        do_reset();
        // R1: all registers hold the safe index, routed lines follow source 0
        chk_all_regs("R1");
        @(negedge clk); src = '0; src[0] = 1'b1; fix = {80{2'b01}};
        chk_out("R1");

        for (int v = 0; v < NVEC; v++) begin
            ln = VEC[v][0]; sv = VEC[v][1];
            wr(ln * RB, sv);
            chk_rd(ln * RB, is_rsvd(ln) ? 0 : sv,
                   is_rsvd(ln) ? "R5" : (is_skip(ln) ? "R6" : "R2"));
            if (is_rsvd(ln)) tag = "R5";
            else if (is_skip(ln)) tag = "R6";
            else if (sv >= NSRC) tag = "R4";
            else tag = "R3";
            @(negedge clk);
            src = '0; fix = {80{2'b10}};
            if (sv < NSRC) src[sv] = 1'b1;
            chk_out(tag);
            @(negedge clk);
            src = ~src; fix = ~fix;
            chk_out(tag);
        end

        // R7: lines 7 and 20 share source 5, lines 8 and 21 share 399
        @(negedge clk); src = '0; src[5] = 1'b1; src[399] = 1'b1;
        #1;
        checks++;
        if (!(ctl[7] && ctl[20] && ctl[8] && ctl[21])) begin
            fails++;
            $display("FAIL R7 fan-out: actual %b%b%b%b expected 1111", ctl[7], ctl[20], ctl[8], ctl[21]);
        end
        chk_out("R7");

        // R2: misaligned and beyond-window writes change nothing, read as 0
        wr(15, 3);
        chk_rd(14, 5, "R2");
        chk_rd(15, 0, "R2");
        wr(320, 7);
        chk_rd(320, 0, "R2");
        chk_all_regs("R2");
        // R2 / R4: full-width value stored, and it routes low
        wr(60, 16'hABCD);
        chk_rd(60, 16'hABCD, "R2");
        @(negedge clk); src = '1;
        chk_out("R4");
        // R5: write to reserved line 3 is dropped, output follows fixed input
        wr(6, 9);
        chk_rd(6, 0, "R5");
        @(negedge clk); fix = '1;
        chk_out("R5");
        @(negedge clk); fix = '0;
        chk_out("R5");

        // R1: reset mid-run restores safe indices
        do_reset();
        chk_all_regs("R1");
        @(negedge clk); src = '0; src[0] = 1'b1; fix = {80{2'b01}};
        chk_out("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule